// File: doc/BRIEF.md
# Output Driver Impedance Calibration Controller

This block is the device-side control logic for calibrating the output driver impedance of a double-data-rate memory. Each extended mode register write carries a 3-bit calibration field. The block decodes that field into one of five actions:

- leave calibration and keep the current setting;
- force the outputs to a fixed high pattern;
- force the outputs to a fixed low pattern;
- enter adjust mode;
- reload the nominal step values.

While a drive pattern is active, the data and strobe outputs carry fixed levels instead of the normal core data. In adjust mode, a write-data start strobe opens a window after the programmed additive latency. Over that window the block samples a 4-bit command one beat at a time from the data pins. It then moves the pull-up and pull-down step counts up or down by one, each on its own, and both counts stay inside a 16-step range.

The two step counts are a single setting shared by every data bit of the device. Calibration only applies when the driver is set to full strength. With half strength selected, requests to adjust or to load the default are ignored.

Top module: `ocd_cal_ctrl`

## Requirements
- R1: After reset, both step outputs read 8, `cal_mode` reads 0 (normal) and `rsvd_flag` is low. The `cal_mode` encoding is: 0 normal, 1 drive-high, 2 drive-low, 3 adjust.
- R2: A write with field 3'b001 selects drive-high. From the next cycle, every `dq_out` and `dqs_out` bit is 1 and every `dqs_n_out` bit is 0.
- R3: A write with field 3'b010 selects drive-low. From the next cycle, `dq_out` and `dqs_out` are 0 and `dqs_n_out` is all ones. In normal mode (field 3'b000) the outputs pass the core inputs through.
- R4: A write with field 3'b100 enters adjust mode only when `bl_is4` is 1 and `half_strength` is 0. Otherwise the write leaves `cal_mode` unchanged.
- R5: A write with field 3'b111 reloads both steps to 8 at the next edge, unless `half_strength` is 1, in which case nothing changes.
- R6: A write with field 3'b000 returns to normal mode and leaves both step values as they are.
- R7: In adjust mode, let the clock edge that samples `wr_start` be edge 0 and let AL be `add_lat`. Beat k (k = 0..3) is sampled at edge AL+1+k. A beat counts as 1 when any `dq_in` bit is high. Beat 0 is DT0 and forms the leftmost bit of the code. The steps change at edge AL+5.
- R8: Code meanings, with the leftmost character being DT0:
  - 0001: pull-up +1
  - 0010: pull-up −1
  - 0100: pull-down +1
  - 1000: pull-down −1
  - 0101: both +1
  - 1010: both −1
  - 0110: pull-down +1 and pull-up −1
  - 1001: pull-down −1 and pull-up +1
  - 0000: no change
- R9: Any code that has both DT2 and DT3 set, or both DT0 and DT1 set, is reserved. It leaves both steps unchanged and pulses `rsvd_flag` for one cycle at the apply edge.
- R10: An increment at step 15 or a decrement at step 0 leaves that step where it is.
- R11: One shared pull-up step and one shared pull-down step apply to the whole DQ bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mrw_valid | input | 1 | Extended mode register write strobe |
| mrw_field | input | 3 | Calibration field of the write (address bits 9..7) |
| half_strength | input | 1 | Reduced drive strength is selected |
| bl_is4 | input | 1 | Programmed burst length is 4 |
| add_lat | input | 3 | Programmed additive latency in cycles |
| wr_start | input | 1 | Write-data start strobe |
| dq_in | input | 16 | Data pins, input side |
| core_dq | input | 16 | Normal read data |
| core_dqs | input | 2 | Normal data strobes |
| core_dqs_n | input | 2 | Normal complementary strobes |
| dq_out | output | 16 | Data pins, output side |
| dqs_out | output | 2 | Data strobes |
| dqs_n_out | output | 2 | Complementary strobes |
| pu_step | output | 4 | Shared pull-up step |
| pd_step | output | 4 | Shared pull-down step |
| cal_mode | output | 2 | Current calibration mode |
| rsvd_flag | output | 1 | Reserved code seen (one-cycle pulse) |

## Verification
The hardest conditions to reach are the saturation edges. Getting a step to 15 or to 0 takes a long series of complete adjust bursts, each with its own latency wait and four timed beats. The bench runs repeated increment bursts past the top, and then repeated decrement bursts past the bottom. It tracks the expected counts in a saturating model, so each overshooting burst is checked at its exact apply cycle. The same burst task also runs with a nonzero additive latency, which moves every beat and the apply edge.

// File: rtl/ocd_pkg.sv
// Shared types and helpers for the output driver calibration controller.
package ocd_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_DRV_HI = 2'd1,
        MODE_DRV_LO = 2'd2,
        MODE_ADJUST = 2'd3
    } cal_mode_e;

    localparam logic [2:0] FLD_EXIT    = 3'b000;
    localparam logic [2:0] FLD_DRV_HI  = 3'b001;
    localparam logic [2:0] FLD_DRV_LO  = 3'b010;
    localparam logic [2:0] FLD_ADJUST  = 3'b100;
    localparam logic [2:0] FLD_DEFAULT = 3'b111;

    // A code is reserved when it asks one driver to rise and fall at once.
    function automatic logic code_reserved(input logic [3:0] c);
        return (c[3] & c[2]) | (c[1] & c[0]);
    endfunction
endpackage

// File: rtl/ocd_mode_decode.sv
// Mode decoder: turns the calibration field of each mode register write into
// a registered calibration mode and a default-load pulse.
// Assumes mrw_valid is a single-cycle strobe in the clock domain.
module ocd_mode_decode
    import ocd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mrw_valid,
    input  logic [2:0] mrw_field,
    input  logic      half_strength,
    input  logic      bl_is4,
    output cal_mode_e mode,
    output logic      load_def
);
    logic adj_ok;
    assign adj_ok = bl_is4 && !half_strength;

    // Default load request, applied by the step registers at this same edge.
    assign load_def = mrw_valid && (mrw_field == FLD_DEFAULT) && !half_strength;

    // Mode register: update on each write; ignored and reserved fields hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_NORMAL;
        end else if (mrw_valid) begin
            case (mrw_field)
                FLD_EXIT:    mode <= MODE_NORMAL;
                FLD_DRV_HI:  mode <= MODE_DRV_HI;
                FLD_DRV_LO:  mode <= MODE_DRV_LO;
                FLD_ADJUST:  if (adj_ok) mode <= MODE_ADJUST;
                FLD_DEFAULT: if (!half_strength) mode <= MODE_NORMAL;
                default:     mode <= mode;
            endcase
        end
    end

    // R4
    adj_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mrw_valid && mrw_field == FLD_ADJUST && !adj_ok && mode != MODE_ADJUST)
        |=> mode != MODE_ADJUST);
endmodule

// File: rtl/ocd_code_capture.sv
// Code capture: after a write start strobe in adjust mode, waits add_lat
// cycles and then shifts in four serial beats (DT0 first, ending up as the
// leftmost bit). Pulses code_vld at the edge that samples the last beat.
// Assumes all DQ bits carry the same code; a beat is 1 if any bit is high.
module ocd_code_capture #(
    parameter int DQ_W = 16,
    parameter int AL_W = 3,
    parameter int BEATS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             wr_start,
    input  logic [AL_W-1:0]  add_lat,
    input  logic [DQ_W-1:0]  dq_in,
    output logic [BEATS-1:0] code,
    output logic             code_vld
);
    localparam int BC_W = $clog2(BEATS);
    localparam logic [BC_W-1:0] LAST_BEAT = BC_W'(BEATS - 1);

    logic            busy;
    logic [AL_W-1:0] wait_cnt;
    logic [BC_W-1:0] beat;
    logic            beat_bit;

    assign beat_bit = |dq_in;

    // Capture sequencer: latency wait, then one shifted beat per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            wait_cnt <= '0;
            beat     <= '0;
            code     <= '0;
            code_vld <= 1'b0;
        end else begin
            code_vld <= 1'b0;
            if (!enable) begin
                busy <= 1'b0;
            end else if (!busy) begin
                if (wr_start) begin
                    busy     <= 1'b1;
                    wait_cnt <= add_lat;
                    beat     <= '0;
                end
            end else if (wait_cnt != '0) begin
                wait_cnt <= wait_cnt - 1'b1;
            end else begin
                code <= {code[BEATS-2:0], beat_bit};
                beat <= beat + 1'b1;
                if (beat == LAST_BEAT) begin
                    busy     <= 1'b0;
                    code_vld <= 1'b1;
                end
            end
        end
    end

    // R7
    vld_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld |-> $past(busy));
endmodule

// File: rtl/ocd_step_sat.sv
// Saturating step register for one driver leg. A default load wins over
// inc/dec; an increment at the top or a decrement at zero has no effect.
module ocd_step_sat #(
    parameter int STEP_W = 4,
    parameter int RESET_STEP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_def,
    input  logic              inc,
    input  logic              dec,
    output logic [STEP_W-1:0] step
);
    localparam logic [STEP_W-1:0] TOP = '1;
    localparam logic [STEP_W-1:0] DEF = STEP_W'(RESET_STEP);

    // Step count update with saturation at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                     step <= DEF;
        else if (load_def)              step <= DEF;
        else if (inc && step != TOP)    step <= step + 1'b1;
        else if (dec && step != '0)     step <= step - 1'b1;
    end

    // R10
    sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == TOP && inc && !load_def) |=> step == TOP);
    // R10
    sat_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == '0 && dec && !inc && !load_def) |=> step == '0);
endmodule

// File: rtl/ocd_cal_ctrl.sv
// Output driver calibration controller (top). Decodes the calibration field,
// forces drive patterns onto DQ/DQS/DQS#, captures adjust codes and keeps
// one shared pull-up and one shared pull-down step for the whole DQ bus.
// Assumes mode register writes and write-start strobes are synchronous.
module ocd_cal_ctrl
    import ocd_pkg::*;
#(
    parameter int DQ_W = 16,
    parameter int DQS_W = 2,
    parameter int STEP_W = 4,
    parameter int RESET_STEP = 8,
    parameter int AL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrw_valid,
    input  logic [2:0]        mrw_field,
    input  logic              half_strength,
    input  logic              bl_is4,
    input  logic [AL_W-1:0]   add_lat,
    input  logic              wr_start,
    input  logic [DQ_W-1:0]   dq_in,
    input  logic [DQ_W-1:0]   core_dq,
    input  logic [DQS_W-1:0]  core_dqs,
    input  logic [DQS_W-1:0]  core_dqs_n,
    output logic [DQ_W-1:0]   dq_out,
    output logic [DQS_W-1:0]  dqs_out,
    output logic [DQS_W-1:0]  dqs_n_out,
    output logic [STEP_W-1:0] pu_step,
    output logic [STEP_W-1:0] pd_step,
    output logic [1:0]        cal_mode,
    output logic              rsvd_flag
);
    localparam int BEATS = 4;
    localparam int LEGS = 2; // index 0 pull-up, 1 pull-down

    cal_mode_e         mode;
    logic              load_def;
    logic [BEATS-1:0]  code;
    logic              code_vld;
    logic              rsvd;
    logic [LEGS-1:0]   inc_v, dec_v;
    logic [STEP_W-1:0] step_v [LEGS];

    ocd_mode_decode u_dec (
        .clk(clk), .rst_n(rst_n), .mrw_valid(mrw_valid), .mrw_field(mrw_field),
        .half_strength(half_strength), .bl_is4(bl_is4),
        .mode(mode), .load_def(load_def)
    );

    ocd_code_capture #(.DQ_W(DQ_W), .AL_W(AL_W), .BEATS(BEATS)) u_cap (
        .clk(clk), .rst_n(rst_n), .enable(mode == MODE_ADJUST),
        .wr_start(wr_start), .add_lat(add_lat), .dq_in(dq_in),
        .code(code), .code_vld(code_vld)
    );

    assign rsvd = code_reserved(code);

    // Code to per-leg inc/dec: DT3 pu+, DT2 pu-, DT1 pd+, DT0 pd-.
    always_comb begin
        inc_v = '0;
        dec_v = '0;
        if (code_vld && !rsvd) begin
            inc_v[0] = code[0];
            dec_v[0] = code[1];
            inc_v[1] = code[2];
            dec_v[1] = code[3];
        end
    end

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        ocd_step_sat #(.STEP_W(STEP_W), .RESET_STEP(RESET_STEP)) u_step (
            .clk(clk), .rst_n(rst_n), .load_def(load_def),
            .inc(inc_v[g]), .dec(dec_v[g]), .step(step_v[g])
        );
    end

    assign pu_step  = step_v[0];
    assign pd_step  = step_v[1];
    assign cal_mode = mode;

    // Reserved flag: one-cycle pulse aligned with the apply edge.
    always_ff @(posedge clk) begin
        if (!rst_n) rsvd_flag <= 1'b0;
        else        rsvd_flag <= code_vld && rsvd;
    end

    // Output pattern mux: forced levels in drive modes, core data otherwise.
    always_comb begin
        case (mode)
            MODE_DRV_HI: begin
                dq_out = '1; dqs_out = '1; dqs_n_out = '0;
            end
            MODE_DRV_LO: begin
                dq_out = '0; dqs_out = '0; dqs_n_out = '1;
            end
            default: begin
                dq_out = core_dq; dqs_out = core_dqs; dqs_n_out = core_dqs_n;
            end
        endcase
    end

    // R9
    rsvd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsvd_flag && !$past(load_def)) |-> ($stable(pu_step) && $stable(pd_step)));
    // R6
    exit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mrw_valid && mrw_field == FLD_EXIT && !code_vld) |=>
        ($stable(pu_step) && $stable(pd_step)));
    // R5
    half_def_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mrw_valid && mrw_field == FLD_DEFAULT && half_strength && !code_vld) |=>
        ($stable(pu_step) && $stable(pd_step)));
    // R2
    drv_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mrw_valid && mrw_field == FLD_DRV_HI) |=> (&dq_out && &dqs_out && !(|dqs_n_out)));
endmodule

// File: tb/ocd_cal_ctrl_tb.sv
// Directed bench for the calibration controller.
module ocd_cal_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        mrw_valid;
    logic [2:0]  mrw_field;
    logic        half_strength;
    logic        bl_is4;
    logic [2:0]  add_lat;
    logic        wr_start;
    logic [15:0] dq_in, core_dq;
    logic [1:0]  core_dqs, core_dqs_n;
    logic [15:0] dq_out;
    logic [1:0]  dqs_out, dqs_n_out;
    logic [3:0]  pu_step, pd_step;
    logic [1:0]  cal_mode;
    logic        rsvd_flag;

    int tests = 0, fails = 0;
    int exp_pu = 8, exp_pd = 8;

    always #5 clk = ~clk;

    ocd_cal_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .mrw_valid(mrw_valid), .mrw_field(mrw_field),
        .half_strength(half_strength), .bl_is4(bl_is4), .add_lat(add_lat),
        .wr_start(wr_start), .dq_in(dq_in), .core_dq(core_dq),
        .core_dqs(core_dqs), .core_dqs_n(core_dqs_n), .dq_out(dq_out),
        .dqs_out(dqs_out), .dqs_n_out(dqs_n_out), .pu_step(pu_step),
        .pd_step(pd_step), .cal_mode(cal_mode), .rsvd_flag(rsvd_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic mrw(input logic [2:0] f);
        mrw_valid = 1'b1; mrw_field = f;
        @(negedge clk);
        mrw_valid = 1'b0; mrw_field = 3'b000;
    endtask

    function automatic int sat(input int v);
        return (v > 15) ? 15 : (v < 0 ? 0 : v);
    endfunction

    // One adjust burst; checks steps and reserved flag at the apply edge.
    task automatic burst(input logic [3:0] c, input int al, input string req);
        logic rsv;
        rsv = (c[3] & c[2]) | (c[1] & c[0]);
        add_lat = 3'(al);
        wr_start = 1'b1;
        @(negedge clk);
        wr_start = 1'b0;
        repeat (al) @(negedge clk);
        for (int k = 3; k >= 0; k--) begin
            dq_in = {16{c[k]}};
            @(negedge clk);
        end
        dq_in = '0;
        check({req, " steps not yet applied"}, pu_step, exp_pu);
        @(negedge clk);
        if (!rsv) begin
            exp_pu = sat(exp_pu + int'(c[0]) - int'(c[1]));
            exp_pd = sat(exp_pd + int'(c[2]) - int'(c[3]));
        end
        check({req, " pull-up"}, pu_step, exp_pu);
        check({req, " pull-down"}, pd_step, exp_pd);
        check({req, " reserved flag"}, rsvd_flag, rsv);
        @(negedge clk);
        check({req, " flag pulse ends"}, rsvd_flag, 0);
    endtask

    task automatic t_reset();
        check("R1 pu reset", pu_step, 8);
        check("R1 pd reset", pd_step, 8);
        check("R1 mode reset", cal_mode, 0);
        check("R1 flag reset", rsvd_flag, 0);
    endtask

    task automatic t_drive();
        mrw(3'b001);
        check("R2 dq high", dq_out, 16'hFFFF);
        check("R2 dqs high", dqs_out, 3);
        check("R2 dqs_n low", dqs_n_out, 0);
        mrw(3'b010);
        check("R3 dq low", dq_out, 0);
        check("R3 dqs low", dqs_out, 0);
        check("R3 dqs_n high", dqs_n_out, 3);
        mrw(3'b000);
        check("R3 normal passthrough dq", dq_out, 16'hA5C3);
        check("R3 normal passthrough dqs_n", dqs_n_out, 1);
    endtask

    task automatic t_adjust_gate();
        bl_is4 = 1'b0; mrw(3'b100);
        check("R4 adjust blocked by burst length", cal_mode, 0);
        bl_is4 = 1'b1; half_strength = 1'b1; mrw(3'b100);
        check("R4 adjust blocked by half strength", cal_mode, 0);
        half_strength = 1'b0; mrw(3'b100);
        check("R4 adjust entered", cal_mode, 3);
    endtask

    task automatic t_codes();
        burst(4'b0001, 0, "R8 pu up");
        burst(4'b0010, 0, "R8 pu down");
        burst(4'b0100, 1, "R8 pd up AL1");
        burst(4'b1000, 0, "R8 pd down");
        burst(4'b0101, 3, "R8 both up AL3");
        burst(4'b1010, 0, "R8 both down");
        burst(4'b0110, 2, "R8 pd up pu down AL2");
        burst(4'b1001, 0, "R8 pd down pu up");
        burst(4'b0000, 0, "R8 nop");
        burst(4'b0011, 0, "R9 reserved 0011");
        burst(4'b1100, 1, "R9 reserved 1100");
        burst(4'b1111, 0, "R9 reserved 1111");
    endtask

    task automatic t_saturation();
        for (int i = 0; i < 10; i++) burst(4'b0101, 0, "R10 top saturation");
        check("R10 pu at top", pu_step, 15);
        check("R11 pd at top", pd_step, 15);
        for (int i = 0; i < 18; i++) burst(4'b1010, 0, "R10 bottom saturation");
        check("R10 pu at bottom", pu_step, 0);
        check("R11 pd at bottom", pd_step, 0);
    endtask

    task automatic t_exit_default();
        burst(4'b0001, 0, "R7 prep");
        mrw(3'b000);
        check("R6 exit keeps pu", pu_step, exp_pu);
        check("R6 exit keeps pd", pd_step, exp_pd);
        check("R6 exit mode", cal_mode, 0);
        half_strength = 1'b1; mrw(3'b111);
        check("R5 half strength default ignored", pu_step, exp_pu);
        half_strength = 1'b0; mrw(3'b111);
        exp_pu = 8; exp_pd = 8;
        check("R5 default pu", pu_step, 8);
        check("R5 default pd", pd_step, 8);
    endtask

    initial begin
        rst_n = 1'b0; mrw_valid = 1'b0; mrw_field = '0; half_strength = 1'b0;
        bl_is4 = 1'b1; add_lat = '0; wr_start = 1'b0; dq_in = '0;
        core_dq = 16'hA5C3; core_dqs = 2'b10; core_dqs_n = 2'b01;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_drive();
        t_adjust_gate();
        t_codes();
        t_saturation();
        t_exit_default();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule